// File: doc/BRIEF.md
# Port-Tagged Shared Transmit FIFO

This block is one synchronous first-in first-out store that every logical port of a packet transmitter writes into. Alongside its data word, each entry holds an 8-bit port address and start-of-packet and end-of-packet markers. The port address, the data and the markers come out unchanged. There is no scheduler. Entries leave strictly in arrival order, so the logic upstream decides the interleaving of ports and the burst sizes.

A release controller holds the read side back until one of two things is true. Either a whole burst unit of bytes is stored, or an end-of-packet word is already inside. A burst that has started runs until the burst-unit word count is reached or an end-of-packet word leaves, whichever comes first. The downstream ready input normally stalls the read side. A mode input masks that ready input so that the block sends whenever it can.

The write side uses a valid/ready handshake and flags an overflow when a word arrives while the store is full. An empty flag is also provided.

Top module: `ptag_shared_fifo`

## Requirements
- R1: After reset, `empty` is 1, `rdValid` is 0, `overflow` is 0 and `wrReady` is 1.
- R2: Words are read out in the order they were written. Each carries its data, its 8-bit port tag (all 256 values) and its SOP/EOP markers unchanged.
- R3: With DEPTH words stored, `wrReady` is 0. A write attempted then is dropped, and `overflow` is 1 for exactly the one cycle after the attempt. The stored words are unaffected.
- R4: While fewer than BURST_BYTES/(DATA_W/8) words are stored and none of them has EOP set, `rdValid` stays 0.
- R5: Once an EOP word is stored, `rdValid` rises even if fewer words than a burst unit are stored.
- R6: A burst ends after BURST_BYTES/(DATA_W/8) words or on an EOP word, whichever comes first. `rdLast` is 1 only on that final word. Once a burst ends, the release condition of R4/R5 applies again.
- R7: With `ignoreBp` = 0 and `dnReady` = 0, no word is consumed: `rdValid` and the head word hold steady.
- R8: With `ignoreBp` = 1, `dnReady` is disregarded, and every cycle in which `rdValid` is 1 consumes one word.
- R9: `empty` is 1 exactly when no words are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write request |
| wrReady | output | 1 | Store can accept a word |
| wrData | input | DATA_W | Write data word |
| wrPort | input | 8 | Port tag of the written word |
| wrSop | input | 1 | Written word starts a packet |
| wrEop | input | 1 | Written word ends a packet |
| rdValid | output | 1 | Head word is released for transfer |
| rdData | output | DATA_W | Head data word |
| rdPort | output | 8 | Head port tag |
| rdSop | output | 1 | Head SOP marker |
| rdEop | output | 1 | Head EOP marker |
| rdLast | output | 1 | Head word closes the current burst |
| dnReady | input | 1 | Downstream can take a word |
| ignoreBp | input | 1 | 1: disregard dnReady |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| empty | output | 1 | No words stored |

## Verification
A write on one clock edge changes `empty`, `rdValid` and the head fields in the same cycle after that edge, because these outputs decode the occupancy registers without another stage. `overflow` is registered, so it is due in the cycle after the edge that saw the refused write and must clear one cycle later. A transfer consumes the head word on the edge where `rdValid` and the effective ready are both high. The bench drives its inputs and samples the outputs on the falling edge, so every value it checks reflects exactly the rising edges that have passed. It looks for the overflow pulse on the first and second falling edges after the attempt.

// File: rtl/ptag_fifo_pkg.sv
package ptag_fifo_pkg;
  localparam int PORT_W = 8;

  typedef struct packed {
    logic push;
    logic pop;
  } ctl_strobe_t;
endpackage

// File: rtl/ptag_fifo_store.sv
module ptag_fifo_store
  import ptag_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PORT_W-1:0] wrPort,
  input  logic              wrSop,
  input  logic              wrEop,
  output logic [DATA_W-1:0] headData,
  output logic [PORT_W-1:0] headPort,
  output logic              headSop,
  output logic              headEop,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     eopCount,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] memData [DEPTH];
  logic [PORT_W-1:0] memPort [DEPTH];
  logic [1:0]        memMark [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign headData = memData[rdPtr];
  assign headPort = memPort[rdPtr];
  assign headSop  = memMark[rdPtr][1];
  assign headEop  = memMark[rdPtr][0];

  always_ff @(posedge clk) begin
    if (strb.push) begin
      memData[wrPtr] <= wrData;
      memPort[wrPtr] <= wrPort;
      memMark[wrPtr] <= {wrSop, wrEop};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      eopCount <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
      count    <= count + CW'(strb.push) - CW'(strb.pop);
      eopCount <= eopCount + CW'(strb.push && wrEop) - CW'(strb.pop && headEop);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !full);
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty);
  p_eop_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    eopCount <= count);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.pop && !empty) |=> ($stable(headData) && $stable(headPort)));
  p_empty_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.push && !strb.pop) |=> $stable(count));
endmodule

// File: rtl/ptag_fifo_ctl.sv
module ptag_fifo_ctl
  import ptag_fifo_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int BURST_WORDS = 4,
  localparam int CW         = $clog2(DEPTH) + 1,
  localparam int BCW        = $clog2(BURST_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic          dnReady,
  input  logic          ignoreBp,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] eopCount,
  input  logic          full,
  input  logic          empty,
  input  logic          headEop,
  output ctl_strobe_t   strb,
  output logic          rdValid,
  output logic          rdLast,
  output logic          overflow
);
  logic           burstActive;
  logic [BCW-1:0] burstCnt;
  logic           releaseOk;
  logic           lastWord;
  logic           go;

  assign releaseOk = (count >= CW'(BURST_WORDS)) || (eopCount != '0);
  assign rdValid   = !empty && (burstActive || releaseOk);
  assign go        = ignoreBp || dnReady;
  assign lastWord  = headEop || (burstCnt == BCW'(BURST_WORDS - 1));
  assign rdLast    = rdValid && lastWord;
  assign strb.push = wrValid && !full;
  assign strb.pop  = rdValid && go;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      burstCnt    <= '0;
      overflow    <= 1'b0;
    end else begin
      overflow <= wrValid && full;
      if (strb.pop) begin
        if (lastWord) begin
          burstActive <= 1'b0;
          burstCnt    <= '0;
        end else begin
          burstActive <= 1'b1;
          burstCnt    <= burstCnt + 1'b1;
        end
      end
    end
  end

  p_burst_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    burstCnt < BCW'(BURST_WORDS));
  p_ovf_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && full) |=> overflow);
  p_burst_sustain_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !lastWord) |=> rdValid);
endmodule

// File: rtl/ptag_shared_fifo.sv
module ptag_shared_fifo
  import ptag_fifo_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 16,
  parameter int BURST_BYTES = 16,
  localparam int BYTES_W     = DATA_W / 8,
  localparam int BURST_WORDS = BURST_BYTES / BYTES_W,
  localparam int CW          = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [DATA_W-1:0] wrData,
  input  logic [7:0]        wrPort,
  input  logic              wrSop,
  input  logic              wrEop,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        rdPort,
  output logic              rdSop,
  output logic              rdEop,
  output logic              rdLast,
  input  logic              dnReady,
  input  logic              ignoreBp,
  output logic              overflow,
  output logic              empty
);
  ctl_strobe_t   strb;
  logic [CW-1:0] count;
  logic [CW-1:0] eopCount;
  logic          full;

  assign wrReady = !full;

  ptag_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrData(wrData), .wrPort(wrPort), .wrSop(wrSop), .wrEop(wrEop),
    .headData(rdData), .headPort(rdPort), .headSop(rdSop), .headEop(rdEop),
    .count(count), .eopCount(eopCount), .full(full), .empty(empty)
  );

  ptag_fifo_ctl #(.DEPTH(DEPTH), .BURST_WORDS(BURST_WORDS)) u_ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .dnReady(dnReady),
    .ignoreBp(ignoreBp), .count(count), .eopCount(eopCount), .full(full),
    .empty(empty), .headEop(rdEop), .strb(strb), .rdValid(rdValid),
    .rdLast(rdLast), .overflow(overflow)
  );
endmodule

// File: tb/ptag_shared_fifo_tb.sv
`timescale 1ns/1ps
module ptag_shared_fifo_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrValid = 0, wrSop = 0, wrEop = 0, dnReady = 0, ignoreBp = 0;
  logic [31:0] wrData = '0;
  logic [7:0]  wrPort = '0;
  logic        wrReady, rdValid, rdSop, rdEop, rdLast, overflow, empty;
  logic [31:0] rdData;
  logic [7:0]  rdPort;
  int checks = 0, errors = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  ptag_shared_fifo u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
    .wrData(wrData), .wrPort(wrPort), .wrSop(wrSop), .wrEop(wrEop),
    .rdValid(rdValid), .rdData(rdData), .rdPort(rdPort), .rdSop(rdSop),
    .rdEop(rdEop), .rdLast(rdLast), .dnReady(dnReady), .ignoreBp(ignoreBp),
    .overflow(overflow), .empty(empty)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [7:0] p, input logic s, input logic e);
    @(negedge clk);
    wrValid = 1; wrData = d; wrPort = p; wrSop = s; wrEop = e;
    @(posedge clk);
    @(negedge clk);
    wrValid = 0;
  endtask

  // consume one word with dnReady, checking all head fields
  task automatic rd(input logic [31:0] d, input logic [7:0] p, input logic s,
                    input logic e, input logic last, input string req);
    chk(rdValid === 1'b1, req, rdValid, 1);
    chk(rdData === d && rdPort === p, req, {rdPort, rdData}, {p, d});
    chk(rdSop === s && rdEop === e && rdLast === last, req,
        {rdSop, rdEop, rdLast}, {s, e, last});
    dnReady = 1;
    @(posedge clk);
    @(negedge clk);
    dnReady = 0;
  endtask

  task automatic t_reset;  // R1, R9
    chk(empty === 1 && rdValid === 0 && overflow === 0 && wrReady === 1, "R1",
        {empty, rdValid, overflow, wrReady}, 4'b1001);
  endtask

  task automatic t_threshold;  // R4, R2, R6, R9
    for (int i = 0; i < 3; i++) wr(32'hA000 + i, 8'd10 + 8'(i), i == 0, 0);
    chk(rdValid === 0, "R4", rdValid, 0);
    chk(empty === 0, "R9", empty, 0);
    wr(32'hA003, 8'd255, 0, 0);
    for (int i = 0; i < 3; i++) rd(32'hA000 + i, 8'd10 + 8'(i), i == 0, 0, 0, "R2");
    rd(32'hA003, 8'd255, 0, 0, 1, "R6");
    chk(empty === 1 && rdValid === 0, "R9", {empty, rdValid}, 2'b10);
  endtask

  task automatic t_eop_release;  // R5, R6
    wr(32'hB000, 8'd0, 1, 0);
    chk(rdValid === 0, "R4", rdValid, 0);
    wr(32'hB001, 8'd7, 0, 1);
    chk(rdValid === 1, "R5", rdValid, 1);
    rd(32'hB000, 8'd0, 1, 0, 0, "R5");
    rd(32'hB001, 8'd7, 0, 1, 1, "R6");
    chk(empty === 1, "R9", empty, 1);
  endtask

  task automatic t_burst_split;  // R6
    for (int i = 0; i < 6; i++) wr(32'hC000 + i, 8'd3, i == 0, 0);
    for (int i = 0; i < 4; i++) rd(32'hC000 + i, 8'd3, i == 0, 0, i == 3, "R6");
    chk(rdValid === 0 && empty === 0, "R6", {rdValid, empty}, 2'b00);
    wr(32'hC006, 8'd3, 0, 1);
    rd(32'hC004, 8'd3, 0, 0, 0, "R6");
    rd(32'hC005, 8'd3, 0, 0, 0, "R6");
    rd(32'hC006, 8'd3, 0, 1, 1, "R6");
  endtask

  task automatic t_stall;  // R7
    for (int i = 0; i < 4; i++) wr(32'hD000 + i, 8'd128, 0, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rdValid === 1 && rdData === 32'hD000 && empty === 0, "R7", rdData, 32'hD000);
    end
    for (int i = 0; i < 4; i++) rd(32'hD000 + i, 8'd128, 0, 0, i == 3, "R7");
  endtask

  task automatic t_ignore;  // R8
    ignoreBp = 1;
    dnReady = 0;
    for (int i = 0; i < 4; i++) wr(32'hE000 + i, 8'd200, 0, 0);
    for (int i = 0; i < 4; i++) begin
      chk(rdValid === 1 && rdData === 32'hE000 + i, "R8", rdData, 32'hE000 + i);
      @(negedge clk);
    end
    chk(empty === 1 && rdValid === 0, "R8", {empty, rdValid}, 2'b10);
    ignoreBp = 0;
  endtask

  task automatic t_overflow;  // R3
    for (int i = 0; i < 16; i++) wr(32'hF000 + i, 8'(i * 16), 0, 0);
    chk(wrReady === 0, "R3", wrReady, 0);
    chk(overflow === 0, "R3", overflow, 0);
    wr(32'hDEAD, 8'd99, 0, 1);
    chk(overflow === 1, "R3", overflow, 1);
    @(negedge clk);
    chk(overflow === 0, "R3", overflow, 0);
    for (int i = 0; i < 16; i++) rd(32'hF000 + i, 8'(i * 16), 0, 0, (i % 4) == 3, "R3");
    chk(empty === 1 && wrReady === 1, "R3", {empty, wrReady}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_eop_release();
    t_burst_split();
    t_stall();
    t_ignore();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule